// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block starts a current-mode power controller gently. The sequence begins when a start request arrives. It then raises the peak-current-limit code through a fixed number of equal-time steps, from a low initial code up to the normal operating code. The total time is set by a count of timing ticks. With the default parameters there are four steps, and a 1 µs tick gives 3 ms per step and 12 ms in total. The codes run from 30 to 80, in units equivalent to 10 mV, so 0.3 V rises to 0.8 V.

When the last step has run its full time, the block holds the final code and raises a done flag. Frequency jittering is enabled only from that point onward. An auto-restart request restarts the sequence from the first step at any time. The code that leaves the block is the smaller of the sequence code and an external cap supplied by other limiting logic.

Top module: `softstart_seq`

## Requirements
- R1: After reset the block is idle: step index 0, done low, jitter enable low, and the sequence code equals the initial code. Ticks arriving while idle do not start or advance anything.
- R2: A start pulse while idle begins the sequence at step 0 on the next clock edge.
- R3: A step ends after exactly TICKS_PER_STEP clock edges at which tick is high. Cycles without tick never advance the step.
- R4: The code of step i is CODE_START + floor((CODE_FINAL − CODE_START)·i / (STEPS − 1)). Step 0 gives the initial code and step STEPS−1 gives the final code.
- R5: After STEPS·TICKS_PER_STEP ticks the done flag rises. From then on the step index stays at STEPS−1 and the code stays at CODE_FINAL, whatever ticks arrive, until a restart.
- R6: The jitter enable output is high exactly when done is high.
- R7: A restart pulse, in any state and even together with a tick, returns the sequence to step 0 with its tick count cleared and done low.
- R8: A start pulse while the sequence is running or done has no effect.
- R9: The output limit code equals the minimum of the current step code and the ext_cap input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the sequence from idle (supply-on condition reached) |
| restart | input | 1 | Auto-restart event; restarts the sequence at step 0 |
| tick | input | 1 | Timing tick, one clock wide |
| ext_cap | input | CODE_W | Limit code from other limiting logic |
| limit_code | output | CODE_W | Active peak-current-limit code |
| step_idx | output | STEP_W | Current step index |
| done | output | 1 | Soft-start finished |
| jitter_en | output | 1 | Frequency jitter permitted |

## Verification
A tick counter stuck at the wrong count moves the step index early or late at the port, so the error shows within one step time. A wrong state bit shows up differently. Either done rises while step_idx is still below the last step, or a start pulse while running resets the step, and both are visible on the next clock edge. A wrong code-table entry or a broken minimum-select appears on limit_code in the same cycle that the step is entered or the cap changes.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_RUN  = 2'd1,
    SS_DONE = 2'd2
  } ss_state_e;

  // Evenly spaced code for step idx between the first and last code.
  function automatic int step_code(input int idx, input int first_code,
                                   input int last_code, input int n_steps);
    int span;
    span = last_code - first_code;
    return first_code + (span * idx) / (n_steps - 1);
  endfunction

endpackage

// File: rtl/ss_dwell_timer.sv
module ss_dwell_timer #(
  parameter int TICKS_PER_STEP = 3000,
  localparam int CNT_W = (TICKS_PER_STEP > 2) ? $clog2(TICKS_PER_STEP) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic step_end
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_STEP - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             count_ev;

  assign count_ev = run && tick;
  assign step_end = count_ev && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clear)       cnt_q <= '0;
    else if (step_end)    cnt_q <= '0;
    else if (count_ev)    cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/ss_step_ctrl.sv
module ss_step_ctrl
  import ss_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int STEP_W = (STEPS > 2) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              restart,
  input  logic              step_end,
  output logic [STEP_W-1:0] step,
  output logic              running,
  output logic              finished,
  output logic              timer_clear
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  ss_state_e         state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              launch;

  assign launch      = (state_q == SS_IDLE) && start;
  assign timer_clear = restart || launch;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    if (restart) begin
      state_d = SS_RUN;
      step_d  = '0;
    end else begin
      unique case (state_q)
        SS_IDLE: if (start) begin
          state_d = SS_RUN;
          step_d  = '0;
        end
        SS_RUN: if (step_end) begin
          if (step_q == LAST_STEP) state_d = SS_DONE;
          else                     step_d  = step_q + 1'b1;
        end
        SS_DONE: ;
        default: state_d = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SS_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign step     = step_q;
  assign running  = (state_q == SS_RUN);
  assign finished = (state_q == SS_DONE);

  p_restart_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (step == '0) && !finished && running);

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !finished && start && !restart) |=> running && (step == '0));

  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !restart) |=> finished && $stable(step));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start && !restart && !step_end) |=> $stable(step) && running);

  p_done_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> (step == LAST_STEP));

endmodule

// File: rtl/ss_limit_sel.sv
module ss_limit_sel
  import ss_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int STEPS      = 4,
  parameter int CODE_START = 30,
  parameter int CODE_FINAL = 80,
  localparam int STEP_W = (STEPS > 2) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic              finished,
  input  logic [CODE_W-1:0] cap,
  output logic [CODE_W-1:0] limit
);
  logic [CODE_W-1:0] lvl [STEPS];
  logic [CODE_W-1:0] seq_code;

  for (genvar g = 0; g < STEPS; g++) begin : g_lvl
    assign lvl[g] = CODE_W'(step_code(g, CODE_START, CODE_FINAL, STEPS));
  end

  assign seq_code = lvl[step];
  assign limit    = (cap < seq_code) ? cap : seq_code;

  p_min_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (limit <= cap) && (limit <= seq_code) && ((limit == cap) || (limit == seq_code)));

  p_final_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> (seq_code == CODE_W'(CODE_FINAL)));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int CODE_W         = 8,
  parameter int STEPS          = 4,
  parameter int TICKS_PER_STEP = 3000,
  parameter int CODE_START     = 30,
  parameter int CODE_FINAL     = 80,
  localparam int STEP_W = (STEPS > 2) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              restart,
  input  logic              tick,
  input  logic [CODE_W-1:0] ext_cap,
  output logic [CODE_W-1:0] limit_code,
  output logic [STEP_W-1:0] step_idx,
  output logic              done,
  output logic              jitter_en
);
  logic step_end;
  logic running;
  logic finished;
  logic timer_clear;

  ss_dwell_timer #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (timer_clear),
    .run      (running),
    .tick     (tick),
    .step_end (step_end)
  );

  ss_step_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .restart     (restart),
    .step_end    (step_end),
    .step        (step_idx),
    .running     (running),
    .finished    (finished),
    .timer_clear (timer_clear)
  );

  ss_limit_sel #(
    .CODE_W(CODE_W), .STEPS(STEPS),
    .CODE_START(CODE_START), .CODE_FINAL(CODE_FINAL)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step_idx),
    .finished (finished),
    .cap      (ext_cap),
    .limit    (limit_code)
  );

  assign done      = finished;
  assign jitter_en = finished;

  p_step_only_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(step_idx) && $stable(done));

  p_no_jitter_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jitter_en) |-> $past(running) && $past(tick));

endmodule

// File: tb/test_softstart_seq.sv
module test_softstart_seq;
  localparam int CW = 8;
  localparam int NS = 4;
  localparam int TK = 2;
  localparam int C0 = 30;
  localparam int C1 = 80;

  typedef struct packed {
    logic          st;
    logic          rs;
    logic          tk;
    logic [CW-1:0] cap;
    logic [1:0]    es;
    logic          ed;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,8'hFF,2'd0,1'b0},  // R1 idle
    '{1'b0,1'b0,1'b1,8'hFF,2'd0,1'b0},  // R1 tick while idle
    '{1'b1,1'b0,1'b0,8'hFF,2'd0,1'b0},  // R2 start
    '{1'b0,1'b0,1'b1,8'hFF,2'd0,1'b0},  // R3 tick 1
    '{1'b0,1'b0,1'b0,8'hFF,2'd0,1'b0},  // R3 no tick
    '{1'b0,1'b0,1'b1,8'hFF,2'd1,1'b0},  // R3 step 1
    '{1'b1,1'b0,1'b0,8'hFF,2'd1,1'b0},  // R8 start ignored
    '{1'b0,1'b0,1'b1,8'hFF,2'd1,1'b0},
    '{1'b0,1'b0,1'b1,8'hFF,2'd2,1'b0},  // R4 step 2
    '{1'b0,1'b0,1'b1,8'hFF,2'd2,1'b0},
    '{1'b0,1'b0,1'b1,8'hFF,2'd3,1'b0},
    '{1'b0,1'b0,1'b1,8'hFF,2'd3,1'b0},
    '{1'b0,1'b0,1'b1,8'hFF,2'd3,1'b1},  // R5 done
    '{1'b0,1'b0,1'b1,8'hFF,2'd3,1'b1},  // R5 hold
    '{1'b1,1'b0,1'b0,8'hFF,2'd3,1'b1},  // R8 start in done
    '{1'b0,1'b0,1'b0,8'd50,2'd3,1'b1},  // R9 cap below
    '{1'b0,1'b1,1'b0,8'hFF,2'd0,1'b0},  // R7 restart
    '{1'b0,1'b0,1'b1,8'd20,2'd0,1'b0},  // R9 cap
    '{1'b0,1'b0,1'b1,8'hFF,2'd1,1'b0},
    '{1'b0,1'b1,1'b1,8'hFF,2'd0,1'b0},  // R7 restart with tick
    '{1'b0,1'b0,1'b1,8'hFF,2'd0,1'b0},
    '{1'b0,1'b0,1'b1,8'hFF,2'd1,1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          restart = 1'b0;
  logic          tick = 1'b0;
  logic [CW-1:0] ext_cap = '1;
  logic [CW-1:0] limit_code;
  logic [1:0]    step_idx;
  logic          done;
  logic          jitter_en;

  int checks = 0;
  int errors = 0;
  bit finished_run = 1'b0;

  always #4 clk = ~clk;

  softstart_seq #(
    .CODE_W(CW), .STEPS(NS), .TICKS_PER_STEP(TK),
    .CODE_START(C0), .CODE_FINAL(C1)
  ) i_softstart_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .restart(restart), .tick(tick),
    .ext_cap(ext_cap), .limit_code(limit_code), .step_idx(step_idx),
    .done(done), .jitter_en(jitter_en)
  );

  // Expected code of step i, R4, done by repeated subtraction
  function automatic int exp_code(input int i);
    int num, q;
    num = (C1 - C0) * i;
    q = 0;
    while (num >= NS - 1) begin
      num -= NS - 1;
      q++;
    end
    return C0 + q;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int es, input int ed, input int cap);
    int lv;
    lv = exp_code(es);
    if (cap < lv) lv = cap;
    chk({tag, " step"}, int'(step_idx), es);
    chk({tag, " done"}, int'(done), ed);
    chk({"R6 jitter"}, int'(jitter_en), ed);
    chk({"R9/R4 limit"}, int'(limit_code), lv);
  endtask

  task automatic apply(input logic s, input logic r, input logic t, input logic [CW-1:0] c);
    @(negedge clk);
    start = s; restart = r; tick = t; ext_cap = c;
    @(posedge clk);
    #1;
    start = 0; restart = 0; tick = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1 reset", 0, 0, 255);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v].st, VEC[v].rs, VEC[v].tk, VEC[v].cap);
      chk_all($sformatf("R3 vec%0d", v), int'(VEC[v].es), int'(VEC[v].ed), int'(VEC[v].cap));
    end

    // R5 long hold: finish the sequence and keep ticking
    for (int k = 0; k < NS * TK; k++) apply(1'b0, 1'b0, 1'b1, 8'hFF);
    chk_all("R5 finish", 3, 1, 255);
    for (int k = 0; k < 15; k++) apply(1'b0, 1'b0, 1'b1, 8'hFF);
    chk_all("R5 held", 3, 1, 255);
    chk("R5 final code", int'(limit_code), C1);

    // R1 reset mid-run, then ticks while idle
    apply(1'b0, 1'b1, 1'b0, 8'hFF);
    apply(1'b0, 1'b0, 1'b1, 8'hFF);
    apply(1'b0, 1'b0, 1'b1, 8'hFF);
    chk_all("R7 mid", 1, 0, 255);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_all("R1 async reset", 0, 0, 255);
    for (int k = 0; k < 5; k++) apply(1'b0, 1'b0, 1'b1, 8'hFF);
    chk_all("R1 idle ticks", 0, 0, 255);
    chk("R4 first code", int'(limit_code), C0);

    // R2 start again and check step time exactly
    apply(1'b1, 1'b0, 1'b0, 8'hFF);
    apply(1'b0, 1'b0, 1'b1, 8'hFF);
    chk_all("R3 one short", 0, 0, 255);
    apply(1'b0, 1'b0, 1'b1, 8'hFF);
    chk_all("R3 exact", 1, 0, 255);

    finished_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule